// File: doc/BRIEF.md
# Unified Partitioned Physical Register File

This block is the physical register storage of an out-of-order core. Integer, floating-point and condition-code registers share one flat physical index space: the integer class takes the lowest indices, the floating-point class follows it directly, and the condition-code class comes last. Every access presents a flat index together with an access kind. The kind is integer, FP value, FP raw bits or condition code.

The block decodes the index against the half-open range of the requested class. It rebases the index to a local slot and then reads or writes that class's storage. It has one combinational read port and one write port that takes effect on the clock edge. An index outside the requested class raises an error flag. Writes to the hardwired integer zero register are dropped. As a build option, FP value writes to the FP zero slot are also dropped. Class sizes and the total size appear as constant outputs. Renaming, free-list handling and bypassing belong to the surrounding pipeline.

Top module: `prf_unified`

## Requirements
- R1: The kind encoding is 0 = integer, 1 = FP value, 2 = FP raw bits, 3 = condition code. An index is valid for a kind only inside that class's range: integer [0, NUM_INT), FP [NUM_INT, NUM_INT+NUM_FP), condition code [NUM_INT+NUM_FP, total). Any other read sets `rd_err` and returns zero on `rd_data`.
- R2: A write (`wr_en`=1) whose index is outside the range for its kind sets `wr_err` in that cycle and changes no register. `wr_err` is 0 whenever `wr_en` is 0.
- R3: FP and condition-code accesses use the flat index minus the class base as the local slot. Integer accesses use the index unchanged. A valid write is read back at the same flat index and leaves every other index unchanged.
- R4: Integer writes to index INT_ZERO_IDX are discarded, so that register always reads zero.
- R5: With FP_ZERO_EN=1, an FP value write whose local slot equals FP_ZERO_IDX is discarded. An FP raw-bit write to the same slot is always stored.
- R6: The FP value view and the FP raw-bit view read and write the same 64-bit word.
- R7: Condition-code registers hold the low CC_W bits of the write data. Their reads are zero-extended to 64 bits.
- R8: Reads are combinational. A read of the index being written in the same cycle returns the old value, and the new value appears after the rising edge.
- R9: A synchronous reset clears every register to zero.
- R10: `cnt_int`, `cnt_fp`, `cnt_cc` and `cnt_total` are constant outputs equal to NUM_INT, NUM_FP, NUM_CC and their sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx | input | IDX_W | Flat read index |
| rd_kind | input | 2 | Read access kind |
| rd_data | output | 64 | Read data, zero on error |
| rd_err | output | 1 | Read index outside the kind's range |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Flat write index |
| wr_kind | input | 2 | Write access kind |
| wr_data | input | 64 | Write data |
| wr_err | output | 1 | Write index outside the kind's range |
| cnt_int | output | IDX_W+1 | Integer register count |
| cnt_fp | output | IDX_W+1 | FP register count |
| cnt_cc | output | IDX_W+1 | Condition-code register count |
| cnt_total | output | IDX_W+1 | Total register count |

## Verification
The bench builds the block with 4 integer, 3 FP and 2 condition-code registers, a 4-bit index, CC_W=4 and FP zero suppression turned on. At that size the bench can try every index (0 to 15, so the unmapped indices 9 to 15 are included) with every one of the four kinds, as a write and again as a read. After each of those 64 writes it reads back the whole index-by-kind space. This covers every class boundary, both zero registers, the aliasing of the two FP views and the truncation of condition-code data.

// File: rtl/prf_pkg.sv
package prf_pkg;

    localparam int DATA_W = 64;

    // Access kind as seen on the ports.
    typedef enum logic [1:0] {
        AK_INT = 2'd0,
        AK_FPV = 2'd1,
        AK_FPB = 2'd2,
        AK_CC  = 2'd3
    } access_kind_e;

    // Register class an index decodes to.
    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_INT  = 2'd1,
        RC_FP   = 2'd2,
        RC_CC   = 2'd3
    } reg_class_e;

    function automatic reg_class_e kind_class(access_kind_e k);
        case (k)
            AK_INT:         return RC_INT;
            AK_FPV, AK_FPB: return RC_FP;
            default:        return RC_CC;
        endcase
    endfunction

endpackage

// File: rtl/prf_class_decode.sv
module prf_class_decode
    import prf_pkg::*;
#(
    parameter int NUM_INT = 32,
    parameter int NUM_FP  = 32,
    parameter int NUM_CC  = 8,
    parameter int IDX_W   = 7
) (
    input  logic [IDX_W-1:0] idx,
    input  access_kind_e     kind,
    output logic             hit,
    output reg_class_e       cls,
    output logic [IDX_W-1:0] loc
);
    localparam int BASE_FP = NUM_INT;
    localparam int BASE_CC = NUM_INT + NUM_FP;
    localparam int TOTAL   = BASE_CC + NUM_CC;
    localparam int XW      = IDX_W + 1;

    logic [XW-1:0] ix;
    logic          in_int, in_fp, in_cc;

    assign ix     = {1'b0, idx};
    assign in_int = ix < XW'(BASE_FP);
    assign in_fp  = (ix >= XW'(BASE_FP)) && (ix < XW'(BASE_CC));
    assign in_cc  = (ix >= XW'(BASE_CC)) && (ix < XW'(TOTAL));

    always_comb begin
        cls = RC_NONE;
        loc = idx;
        if (in_int) begin
            cls = RC_INT;
        end else if (in_fp) begin
            cls = RC_FP;
            loc = idx - IDX_W'(BASE_FP);
        end else if (in_cc) begin
            cls = RC_CC;
            loc = idx - IDX_W'(BASE_CC);
        end
        hit = (cls != RC_NONE) && (cls == kind_class(kind));
    end

    // The three class ranges never overlap.
    always_comb begin
        assert_one_class_R1: assert ($onehot0({in_int, in_fp, in_cc}));
    end

    // A hit always lands inside its own class storage.
    always_comb begin
        if (hit) begin
            assert_local_in_range_R3: assert (
                (cls == RC_INT && int'(loc) < NUM_INT) ||
                (cls == RC_FP  && int'(loc) < NUM_FP)  ||
                (cls == RC_CC  && int'(loc) < NUM_CC));
        end
    end

endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
    parameter int DEPTH    = 32,
    parameter int W        = 64,
    parameter int AW       = 5,
    parameter int ZERO_EN  = 0,
    parameter int ZERO_IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          zero_guard,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        drop_w;

    assign drop_w = (ZERO_EN != 0) && zero_guard && (waddr == AW'(ZERO_IDX));

    always_comb begin
        st_d = st_q;
        if (we && !drop_w && int'(waddr) < DEPTH) begin
            st_d.mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata = (int'(raddr) < DEPTH) ? st_q.mem[raddr] : '0;

    // Without a write enable the bank keeps its contents.
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(st_q));

    // Reset leaves every word at zero.
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (st_q == '0));

endmodule

// File: rtl/prf_unified.sv
module prf_unified
    import prf_pkg::*;
#(
    parameter int NUM_INT      = 32,
    parameter int NUM_FP       = 32,
    parameter int NUM_CC       = 8,
    parameter int IDX_W        = 7,
    parameter int CC_W         = 8,
    parameter int INT_ZERO_IDX = 0,
    parameter int FP_ZERO_EN   = 0,
    parameter int FP_ZERO_IDX  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [1:0]         rd_kind,
    output logic [63:0]        rd_data,
    output logic               rd_err,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [1:0]         wr_kind,
    input  logic [63:0]        wr_data,
    output logic               wr_err,
    output logic [IDX_W:0]     cnt_int,
    output logic [IDX_W:0]     cnt_fp,
    output logic [IDX_W:0]     cnt_cc,
    output logic [IDX_W:0]     cnt_total
);
    localparam int BASE_FP = NUM_INT;
    localparam int BASE_CC = NUM_INT + NUM_FP;
    localparam int TOTAL   = BASE_CC + NUM_CC;
    localparam int CNT_W   = IDX_W + 1;
    localparam int INT_AW  = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;
    localparam int FP_AW   = (NUM_FP  > 1) ? $clog2(NUM_FP)  : 1;
    localparam int CC_AW   = (NUM_CC  > 1) ? $clog2(NUM_CC)  : 1;

    if (NUM_INT < 1 || NUM_FP < 1 || NUM_CC < 1 ||
        IDX_W != $clog2(TOTAL) || CC_W < 1 || CC_W > DATA_W ||
        INT_ZERO_IDX >= NUM_INT) begin : g_bad_cfg
        $error("prf_unified: illegal parameter set");
    end

    // Constant size outputs, taken from the class boundaries.
    assign cnt_int   = CNT_W'(BASE_FP);
    assign cnt_fp    = CNT_W'(BASE_CC - BASE_FP);
    assign cnt_cc    = CNT_W'(TOTAL - BASE_CC);
    assign cnt_total = CNT_W'(TOTAL);

    // Index decode for both ports.
    logic             r_hit, w_hit;
    reg_class_e       r_cls, w_cls;
    logic [IDX_W-1:0] r_loc, w_loc;
    access_kind_e     r_kind, w_kind;

    assign r_kind = access_kind_e'(rd_kind);
    assign w_kind = access_kind_e'(wr_kind);

    prf_class_decode #(
        .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .NUM_CC(NUM_CC), .IDX_W(IDX_W)
    ) u_rdec (
        .idx(rd_idx), .kind(r_kind), .hit(r_hit), .cls(r_cls), .loc(r_loc)
    );

    prf_class_decode #(
        .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .NUM_CC(NUM_CC), .IDX_W(IDX_W)
    ) u_wdec (
        .idx(wr_idx), .kind(w_kind), .hit(w_hit), .cls(w_cls), .loc(w_loc)
    );

    // Per-class write enables.
    logic we_int, we_fp, we_cc, w_ok;

    assign w_ok   = wr_en && w_hit;
    assign we_int = w_ok && (w_cls == RC_INT);
    assign we_fp  = w_ok && (w_cls == RC_FP);
    assign we_cc  = w_ok && (w_cls == RC_CC);
    assign wr_err = wr_en && !w_hit;

    logic [DATA_W-1:0] int_rd, fp_rd;
    logic [CC_W-1:0]   cc_rd;

    prf_bank #(
        .DEPTH(NUM_INT), .W(DATA_W), .AW(INT_AW),
        .ZERO_EN(1), .ZERO_IDX(INT_ZERO_IDX)
    ) u_int_bank (
        .clk(clk), .rst(rst), .we(we_int), .zero_guard(1'b1),
        .waddr(w_loc[INT_AW-1:0]), .wdata(wr_data),
        .raddr(r_loc[INT_AW-1:0]), .rdata(int_rd)
    );

    // Only the value view of an FP write is subject to zero-slot suppression.
    prf_bank #(
        .DEPTH(NUM_FP), .W(DATA_W), .AW(FP_AW),
        .ZERO_EN(FP_ZERO_EN), .ZERO_IDX(FP_ZERO_IDX)
    ) u_fp_bank (
        .clk(clk), .rst(rst), .we(we_fp), .zero_guard(w_kind == AK_FPV),
        .waddr(w_loc[FP_AW-1:0]), .wdata(wr_data),
        .raddr(r_loc[FP_AW-1:0]), .rdata(fp_rd)
    );

    prf_bank #(
        .DEPTH(NUM_CC), .W(CC_W), .AW(CC_AW),
        .ZERO_EN(0), .ZERO_IDX(0)
    ) u_cc_bank (
        .clk(clk), .rst(rst), .we(we_cc), .zero_guard(1'b0),
        .waddr(w_loc[CC_AW-1:0]), .wdata(wr_data[CC_W-1:0]),
        .raddr(r_loc[CC_AW-1:0]), .rdata(cc_rd)
    );

    // Read return mux.
    always_comb begin
        rd_data = '0;
        if (r_hit) begin
            case (r_cls)
                RC_INT:  rd_data = int_rd;
                RC_FP:   rd_data = fp_rd;
                RC_CC:   rd_data = DATA_W'(cc_rd);
                default: rd_data = '0;
            endcase
        end
        rd_err = !r_hit;
    end

    assert_err_zero_data_R1: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (rd_data == '0));

    assert_int_zero_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_err && rd_kind == 2'd0 && int'(rd_idx) == INT_ZERO_IDX) |-> (rd_data == '0));

    assert_cc_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
        (!rd_err && rd_kind == 2'd3) |-> (rd_data[DATA_W-1:CC_W] == '0));

    assert_wr_err_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !wr_err);

endmodule

// File: tb/prf_unified_tb.sv
`timescale 1ns/1ps
module prf_unified_tb;
    localparam int NI = 4, NF = 3, NC = 2, IW = 4, CW = 4;
    localparam int TOT = NI + NF + NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] rd_idx = '0;
    logic [1:0]    rd_kind = '0;
    logic [63:0]   rd_data;
    logic          rd_err;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [1:0]    wr_kind = '0;
    logic [63:0]   wr_data = '0;
    logic          wr_err;
    logic [IW:0]   cnt_int, cnt_fp, cnt_cc, cnt_total;

    int tests = 0, fails = 0;
    logic [63:0] model [TOT];

    always #5 clk = ~clk;

    prf_unified #(
        .NUM_INT(NI), .NUM_FP(NF), .NUM_CC(NC), .IDX_W(IW), .CC_W(CW),
        .INT_ZERO_IDX(0), .FP_ZERO_EN(1), .FP_ZERO_IDX(0)
    ) u_dut (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_kind(rd_kind),
        .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_kind(wr_kind), .wr_data(wr_data), .wr_err(wr_err),
        .cnt_int(cnt_int), .cnt_fp(cnt_fp), .cnt_cc(cnt_cc), .cnt_total(cnt_total)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit valid(input int i, input int k);
        case (k)
            0:       return i < NI;
            1, 2:    return i >= NI && i < NI + NF;
            default: return i >= NI + NF && i < TOT;
        endcase
    endfunction

    // Update the model as the requirements say a write should.
    function automatic void apply(input int i, input int k, input logic [63:0] d);
        if (!valid(i, k)) return;
        if (k == 0 && i == 0) return;          // R4
        if (k == 1 && i - NI == 0) return;     // R5
        if (k == 3) model[i] = d & 64'hF;      // R7
        else        model[i] = d;
    endfunction

    task automatic rd_chk(input int i, input int k, input string req);
        logic [63:0] e;
        rd_idx = IW'(i); rd_kind = 2'(k);
        #1;
        e = valid(i, k) ? model[i] : 64'h0;
        chk(rd_data == e && rd_err == !valid(i, k), req, rd_data, e);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++)
                rd_chk(i, k, req);
    endtask

    task automatic wr(input int i, input int k, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(i); wr_kind = 2'(k); wr_data = d;
        #1;
        chk(wr_err == !valid(i, k), "R2 wr_err", {63'd0, wr_err}, {63'd0, !valid(i, k)});
        @(posedge clk);
        apply(i, k, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < TOT; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R10 constant sizes
        chk(cnt_int == 5'd4, "R10 cnt_int", 64'(cnt_int), 64'd4);
        chk(cnt_fp == 5'd3, "R10 cnt_fp", 64'(cnt_fp), 64'd3);
        chk(cnt_cc == 5'd2, "R10 cnt_cc", 64'(cnt_cc), 64'd2);
        chk(cnt_total == 5'd9, "R10 cnt_total", 64'(cnt_total), 64'd9);
        chk(wr_err == 1'b0, "R2 idle wr_err", 64'(wr_err), 64'd0);

        // R9 reset state, R1 error map
        read_all("R9/R1 after reset");

        // Exhaustive write sweep: every index with every kind, then full readback (R1 R3 R4 R5 R7)
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 4; k++) begin
                wr(i, k, 64'hC3A5_0000_0000_0000 ^ (64'(i) << 20) ^ (64'(k) << 8) ^ 64'h5F);
                read_all("R3 sweep");
            end

        // R4 integer zero register
        wr(0, 0, 64'hDEAD);
        rd_chk(0, 0, "R4 int zero");
        chk(rd_data == 64'h0, "R4 int zero reads zero", rd_data, 64'h0);

        // R5 raw write to FP slot 0 stored, value write dropped
        wr(4, 2, 64'h1111_2222_3333_4444);
        rd_chk(4, 2, "R5 raw store");
        chk(rd_data == 64'h1111_2222_3333_4444, "R5 raw store", rd_data, 64'h1111_2222_3333_4444);
        wr(4, 1, 64'h9999);
        rd_chk(4, 1, "R5 value dropped");
        chk(rd_data == 64'h1111_2222_3333_4444, "R5 value dropped", rd_data, 64'h1111_2222_3333_4444);

        // R6 shared storage between views
        wr(5, 2, 64'hABCD_EF01_2345_6789);
        rd_chk(5, 1, "R6 raw->value");
        chk(rd_data == 64'hABCD_EF01_2345_6789, "R6 raw->value", rd_data, 64'hABCD_EF01_2345_6789);
        wr(6, 1, 64'h0F0F_F0F0_0F0F_F0F0);
        rd_chk(6, 2, "R6 value->raw");
        chk(rd_data == 64'h0F0F_F0F0_0F0F_F0F0, "R6 value->raw", rd_data, 64'h0F0F_F0F0_0F0F_F0F0);

        // R7 CC truncation and zero extension
        wr(8, 3, 64'hFFFF_FFFF_FFFF_FFFA);
        rd_chk(8, 3, "R7 cc");
        chk(rd_data == 64'hA, "R7 cc zero-ext", rd_data, 64'hA);

        // R2 mismatched writes leave storage alone
        wr(5, 0, 64'h7777); wr(2, 3, 64'h7777); wr(12, 1, 64'h7777);
        read_all("R2 no side effect");

        // R8 read-during-write returns old value
        wr(1, 0, 64'h0000_0000_0000_0111);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd1; wr_kind = 2'd0; wr_data = 64'h0000_0000_0000_0222;
        rd_idx = 4'd1; rd_kind = 2'd0;
        #1;
        chk(rd_data == 64'h111, "R8 old value", rd_data, 64'h111);
        @(posedge clk);
        #1;
        chk(rd_data == 64'h222, "R8 new value", rd_data, 64'h222);
        model[1] = 64'h222;
        @(negedge clk); wr_en = 1'b0;

        // R9 reset again clears everything
        rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < TOT; i++) model[i] = '0;
        read_all("R9 re-reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule